// File: doc/BRIEF.md
# Lane-Splittable Binary Adder

This block adds two operands of equal width with no clock. An enable vector, one bit per fixed split position, breaks the adder into independent lanes. With every enable bit low, the block is a plain adder whose result wraps at the full width. With an enable bit high, no carry crosses that position, so each lane wraps at its own width.

The block does not build separate adders or select carries. It widens both operands by one spare bit below each split position. In the first operand the spare bit is 1 when its split is off, so an arriving carry ripples through it. It is 0 when the split is on, so the carry stops there. In the second operand the spare bits are always 0. One wide addition follows, and then the spare bits are dropped from the result.

Width and split positions are elaboration-time parameters. A typical build is a 32-bit adder that splits on byte boundaries.

Top module: `psa_lane_adder`

## Requirements
- R1: When every bit of `part_en_i` is 0, `sum_o` equals (`a_i` + `b_i`) modulo 2^WIDTH.
- R2: When every bit of `part_en_i` is 1, each lane of `sum_o` (the bits between adjacent split positions) equals the sum of the matching operand slices, modulo 2^(lane width).
- R3: When `part_en_i[k]` is 1, bit PART_POS[k] of `sum_o` equals `a_i` XOR `b_i` at that bit, so no carry from below enters. This holds even when both operands are all ones.
- R4: When `part_en_i[k]` is 0, a carry out of the bits below PART_POS[k] enters bit PART_POS[k]. For every mix of enable bits, the lanes joined by disabled splits behave as one wider adder.
- R5: The lowest lane, bits below the lowest split position, always equals the low bits of `a_i` + `b_i`, whatever `part_en_i` holds.
- R6: Bit k of `part_en_i` controls the k-th lowest split position. Bit 0 is the lowest. PART_POS lists positions in strictly increasing order.
- R7: The block is purely combinational. `sum_o` follows its inputs without any clock, and it has no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| part_en_i | input | N_PARTS | Split enables, bit 0 for the lowest position |
| sum_o | output | WIDTH | Lane-wise sum |

## Verification
The bench builds two instances. The first uses the default 32-bit width with splits at 8, 16 and 24, so every lane is one byte. The second is 12 bits wide with splits at 2 and 9, which gives lanes of 2, 7 and 3 bits. Uneven lanes check that the spare-bit insertion and removal index correctly when lanes are not a power of two and the lowest lane is narrow. Both run every enable combination against a bit-serial carry model that resets its carry at enabled positions. They also get all-ones operands, where any carry leak at an enabled split would be visible.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int unsigned POS_BITS   = 32;
  localparam int unsigned MAX_PARTS  = 32;
  localparam int unsigned POS_VEC_W  = POS_BITS * MAX_PARTS;

  typedef logic [POS_VEC_W-1:0] pos_vec_t;

  function automatic int unsigned pos_at(input pos_vec_t pv, input int unsigned k);
    return int'(pv[k*POS_BITS +: POS_BITS]);
  endfunction

  // index of operand bit in the widened word: one spare bit below each split at or under it
  function automatic int unsigned wide_index(input pos_vec_t pv, input int unsigned n_parts,
                                             input int unsigned bit_idx);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned k = 0; k < n_parts; k++)
      if (pos_at(pv, k) <= bit_idx) cnt++;
    return bit_idx + cnt;
  endfunction

  // spare bit for split k sits just below the (shifted) split position
  function automatic int unsigned guard_index(input pos_vec_t pv, input int unsigned k);
    return pos_at(pv, k) + k;
  endfunction
endpackage

// File: rtl/psa_expand.sv
module psa_expand #(
  parameter int unsigned       WIDTH      = 32,
  parameter int unsigned       N_PARTS    = 3,
  parameter psa_pkg::pos_vec_t POS_EXT    = '0,
  parameter bit                GUARD_PASS = 1'b1,
  localparam int unsigned      WIDE_W     = WIDTH + N_PARTS
) (
  input  logic [WIDTH-1:0]   data_i,
  input  logic [N_PARTS-1:0] part_en_i,
  output logic [WIDE_W-1:0]  wide_o
);
  logic [N_PARTS-1:0] guard;

  // pass operand: spare = 1 lets carry ripple, 0 absorbs it; other operand: always 0
  assign guard = {N_PARTS{GUARD_PASS}} & ~part_en_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_data
    localparam int unsigned WI = psa_pkg::wide_index(POS_EXT, N_PARTS, i);
    assign wide_o[WI] = data_i[i];
  end

  for (genvar k = 0; k < N_PARTS; k++) begin : g_guard
    localparam int unsigned GI = psa_pkg::guard_index(POS_EXT, k);
    assign wide_o[GI] = guard[k];
  end
endmodule

// File: rtl/psa_wide_add.sv
module psa_wide_add #(
  parameter int unsigned W = 35
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  assign s_o = x_i + y_i;
endmodule

// File: rtl/psa_compact.sv
module psa_compact #(
  parameter int unsigned       WIDTH   = 32,
  parameter int unsigned       N_PARTS = 3,
  parameter psa_pkg::pos_vec_t POS_EXT = '0,
  localparam int unsigned      WIDE_W  = WIDTH + N_PARTS
) (
  input  logic [WIDE_W-1:0] wide_i,
  output logic [WIDTH-1:0]  data_o
);
  logic [N_PARTS-1:0] guard_unused;

  for (genvar i = 0; i < WIDTH; i++) begin : g_data
    localparam int unsigned WI = psa_pkg::wide_index(POS_EXT, N_PARTS, i);
    assign data_o[i] = wide_i[WI];
  end

  for (genvar k = 0; k < N_PARTS; k++) begin : g_guard
    localparam int unsigned GI = psa_pkg::guard_index(POS_EXT, k);
    assign guard_unused[k] = wide_i[GI];
  end
endmodule

// File: rtl/psa_lane_adder.sv
module psa_lane_adder #(
  parameter int unsigned               WIDTH    = 32,
  parameter int unsigned               N_PARTS  = 3,
  parameter logic [N_PARTS*32-1:0]     PART_POS = {32'd24, 32'd16, 32'd8}
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [N_PARTS-1:0] part_en_i,
  output logic [WIDTH-1:0]   sum_o
);
  localparam int unsigned       WIDE_W  = WIDTH + N_PARTS;
  localparam psa_pkg::pos_vec_t POS_EXT = psa_pkg::POS_VEC_W'(PART_POS);

  logic [WIDE_W-1:0] a_wide, b_wide, s_wide;

  psa_expand #(.WIDTH(WIDTH), .N_PARTS(N_PARTS), .POS_EXT(POS_EXT), .GUARD_PASS(1'b1)) u_exp_a (
    .data_i(a_i), .part_en_i(part_en_i), .wide_o(a_wide)
  );

  psa_expand #(.WIDTH(WIDTH), .N_PARTS(N_PARTS), .POS_EXT(POS_EXT), .GUARD_PASS(1'b0)) u_exp_b (
    .data_i(b_i), .part_en_i(part_en_i), .wide_o(b_wide)
  );

  psa_wide_add #(.W(WIDE_W)) u_add (
    .x_i(a_wide), .y_i(b_wide), .s_o(s_wide)
  );

  psa_compact #(.WIDTH(WIDTH), .N_PARTS(N_PARTS), .POS_EXT(POS_EXT)) u_cmp (
    .wide_i(s_wide), .data_o(sum_o)
  );
endmodule

// File: rtl/psa_lane_adder_chk.sv
module psa_lane_adder_chk #(
  parameter int unsigned           WIDTH    = 32,
  parameter int unsigned           N_PARTS  = 3,
  parameter logic [N_PARTS*32-1:0] PART_POS = {32'd24, 32'd16, 32'd8}
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic [N_PARTS-1:0] part_en_i,
  input logic [WIDTH-1:0]   sum_o
);
  localparam int unsigned P0 = int'(PART_POS[31:0]);

  always_comb begin
    if (part_en_i == '0)
      AST_FULL_WRAP: assert (sum_o == WIDTH'(a_i + b_i)) else $error("full sum mismatch"); // R1
    AST_LOW_LANE: assert (sum_o[P0-1:0] == P0'(a_i[P0-1:0] + b_i[P0-1:0])) else $error("low lane"); // R5
  end

  for (genvar k = 0; k < N_PARTS; k++) begin : g_split
    localparam int unsigned P = int'(PART_POS[k*32 +: 32]);
    always_comb begin
      if (part_en_i[k])
        AST_NO_CARRY_IN: assert (sum_o[P] == (a_i[P] ^ b_i[P])) else $error("carry leak"); // R3
    end
  end

  for (genvar l = 0; l <= N_PARTS; l++) begin : g_lane
    localparam int unsigned LO = (l == 0) ? 0 : int'(PART_POS[(l-1)*32 +: 32]);
    localparam int unsigned HI = (l == N_PARTS) ? WIDTH : int'(PART_POS[l*32 +: 32]);
    localparam int unsigned LW = HI - LO;
    always_comb begin
      if (&part_en_i)
        AST_LANE_WRAP: assert (sum_o[HI-1:LO] == LW'(a_i[HI-1:LO] + b_i[HI-1:LO])) else $error("lane"); // R2
    end
  end
endmodule

bind psa_lane_adder psa_lane_adder_chk #(
  .WIDTH(WIDTH), .N_PARTS(N_PARTS), .PART_POS(PART_POS)
) u_chk (
  .a_i(a_i), .b_i(b_i), .part_en_i(part_en_i), .sum_o(sum_o)
);

// File: tb/psa_lane_adder_tb_top.sv
`timescale 1ns/1ps
module psa_lane_adder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b, s;
  logic [2:0]  en;
  logic [11:0] a2, b2, s2;
  logic [1:0]  en2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  psa_lane_adder dut_i (.a_i(a), .b_i(b), .part_en_i(en), .sum_o(s));

  psa_lane_adder #(.WIDTH(12), .N_PARTS(2), .PART_POS({32'd9, 32'd2})) dut_odd_i (
    .a_i(a2), .b_i(b2), .part_en_i(en2), .sum_o(s2)
  );

  typedef struct {
    logic [31:0] exp;
    logic [11:0] exp2;
    string       tag;
  } item_t;
  item_t sb[$];

  // bit-serial carry model: carry cleared at each enabled split
  function automatic logic [31:0] ref_sum(input logic [31:0] x, input logic [31:0] y,
                                          input logic [31:0] brk, input int w);
    logic [31:0] r;
    logic c;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < w; i++) begin
      if (brk[i]) c = 1'b0;
      r[i] = x[i] ^ y[i] ^ c;
      c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] xa, input logic [31:0] xb, input logic [2:0] xe,
                       input logic [11:0] ya, input logic [11:0] yb, input logic [1:0] ye,
                       input string tag);
    item_t it;
    logic [31:0] brk, brk2;
    @(posedge clk);
    brk  = '0;
    brk[8] = xe[0]; brk[16] = xe[1]; brk[24] = xe[2];
    brk2 = '0;
    brk2[2] = ye[0]; brk2[9] = ye[1];
    it.exp  = ref_sum(xa, xb, brk, 32);
    it.exp2 = ref_sum({20'd0, ya}, {20'd0, yb}, brk2, 12)[11:0];
    it.tag  = tag;
    a = xa; b = xb; en = xe;
    a2 = ya; b2 = yb; en2 = ye;
    sb.push_back(it);
  endtask

  // monitor: output sampled half a cycle after the inputs change (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_tests += 2;
        if (s !== it.exp) begin
          n_fail++;
          $display("FAIL %s w32: actual %h expected %h", it.tag, s, it.exp);
        end
        if (s2 !== it.exp2) begin
          n_fail++;
          $display("FAIL %s w12: actual %h expected %h", it.tag, s2, it.exp2);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; en = '0; a2 = '0; b2 = '0; en2 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // zero inputs give zero, no stored state (R7)
    drive('0, '0, 3'b000, '0, '0, 2'b00, "R7 zero");
    // all-ones: carry must stop at each enabled split (R3) and pass at disabled ones (R4)
    for (int e = 0; e < 8; e++)
      drive('1, '1, 3'(e), '1, '1, 2'(e), "R3 R4 all-ones");
    // split ordering: bit 0 is the lowest position (R6)
    drive(32'h0000_00FF, 32'h1, 3'b001, 12'h003, 12'h001, 2'b01, "R6 low split");
    drive(32'h00FF_FFFF, 32'h1, 3'b100, 12'h1FF, 12'h001, 2'b10, "R6 high split");
    drive(32'h00FF_FFFF, 32'h1, 3'b011, 12'h1FF, 12'h001, 2'b01, "R6 mixed");
    for (int e = 0; e < 8; e++) begin
      for (int n = 0; n < 150; n++) begin
        string tg;
        if (e == 0)      tg = "R1 R5 no split";
        else if (e == 7) tg = "R2 R5 all split";
        else             tg = "R4 R5 mixed";
        drive($urandom, $urandom, 3'(e), 12'($urandom), 12'($urandom), 2'(e), tg);
      end
    end
    // carry-heavy patterns at lane tops
    for (int e = 0; e < 8; e++)
      drive(32'h7F7F_7F7F, 32'h8181_8181, 3'(e), 12'h1FD, 12'h603, 2'(e), "R3 R4 edge");
    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule